// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned word by another over several clock cycles and produces one quotient bit per cycle. A request is made by pulsing `start_i` with the operands present. The block then runs one add-or-subtract step per quotient bit. The direction of each step depends on the sign of the running partial remainder, so a negative partial remainder is never restored on the spot. One closing cycle adds the divisor back if the final partial remainder is negative. The quotient then appears on `lo_o`, the remainder on `hi_o`, and `done_o` pulses for one cycle.

A zero divisor is not iterated. It completes on the next edge with the divide-by-zero flag raised, the quotient all ones and the remainder equal to the dividend. Only single-width dividends are taken, and quotient overflow is not reported. The results stay on the outputs until the next request completes. This lets a consumer pick them up at any later time.

Top module: `nr_divider`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `div_zero_o` are 0 and `lo_o` and `hi_o` are all zeros.
- R2: A `start_i` sampled while `busy_o` is 0 with a nonzero divisor raises `busy_o` from the next cycle for exactly WIDTH+1 cycles. `done_o` is 1 for the single cycle right after the last busy cycle, and `busy_o` and `done_o` are never 1 together.
- R3: At completion of a nonzero-divisor request, `lo_o` equals the integer quotient floor(dividend / divisor).
- R4: At completion of a nonzero-divisor request, `hi_o` equals dividend − quotient × divisor, which is always less than the divisor.
- R5: A `start_i` sampled while idle with divisor 0 sets `done_o` and `div_zero_o` on the next cycle, puts all ones on `lo_o` and the dividend on `hi_o`, and never raises `busy_o`.
- R6: `div_zero_o` holds its value until the next completion, and a completion with a nonzero divisor clears it to 0.
- R7: `start_i` while `busy_o` is 1 is ignored: the running request finishes with its original operands and unchanged timing.
- R8: `lo_o` and `hi_o` do not change while `busy_o` is 1 or while the block is idle; they change only on the cycle `done_o` rises.
- R9: Divisors with the top bit set, divisor 1, a dividend smaller than the divisor, a zero dividend and an all-ones dividend all give the results of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only when idle |
| dividend_i | input | WIDTH | Dividend, sampled with an accepted start |
| divisor_i | input | WIDTH | Divisor, sampled with an accepted start |
| busy_o | output | 1 | A division is iterating or correcting |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last completed request had a zero divisor |
| lo_o | output | WIDTH | Quotient of the last completed request |
| hi_o | output | WIDTH | Remainder of the last completed request |

## Verification
Fixed operand pairs are run first. A small worked case shows the add-after-negative steps and the final add-back. Divisor 1 and a divisor equal to the dividend separate a correct quotient from a bit shifted off by one position. A dividend below the divisor and a zero dividend show whether the correction step fires when it should. Divisors with the top bit set, and an all-ones dividend, expose a partial remainder without its extra sign bit. Next come zero divisors, including one placed straight after a normal request. This separates the idle-path result from the iterating one and checks that the flag clears again. A start pulse placed in the middle of a busy period shows whether operands are re-sampled. Random operands with divisor widths spread across the whole range then cover the rest.

// File: rtl/nrdiv_pkg.sv
// Package: shared types for the non-restoring divider.
// Assumes nothing beyond IEEE 1800-2017 packages.
package nrdiv_pkg;

    // Sequencer phases: waiting, one quotient bit per cycle, final add-back.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ITER = 2'd1,
        PH_FIX  = 2'd2
    } nrdiv_phase_e;

    // Add-or-subtract choice for one recurrence step.
    typedef enum logic {
        OP_SUB = 1'b0,
        OP_ADD = 1'b1
    } nrdiv_op_e;

endpackage

// File: rtl/nrdiv_ctrl.sv
// Module: nrdiv_ctrl
// Sequences one division: accepts a request only when idle, runs WIDTH
// iteration cycles followed by one correction cycle, and short-circuits a
// zero divisor straight to completion. Assumes WIDTH >= 2.
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic div_is_zero_i,
    output logic load_o,
    output logic zload_o,
    output logic iter_o,
    output logic fix_o,
    output logic busy_o,
    output logic done_o
);

    localparam int              CNT_W    = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(WIDTH - 1);

    nrdiv_phase_e     phase_q;
    logic [CNT_W-1:0] iter_cnt_q;
    logic             done_q;
    logic             accept;

    // Request acceptance and the phase decodes used by the datapath.
    always_comb begin
        accept  = start_i && (phase_q == PH_IDLE);
        load_o  = accept && !div_is_zero_i;
        zload_o = accept && div_is_zero_i;
        iter_o  = (phase_q == PH_ITER);
        fix_o   = (phase_q == PH_FIX);
        busy_o  = (phase_q != PH_IDLE);
        done_o  = done_q;
    end

    // Phase register and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            iter_cnt_q <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    iter_cnt_q <= '0;
                    if (load_o) phase_q <= PH_ITER;
                end
                PH_ITER: begin
                    iter_cnt_q <= iter_cnt_q + 1'b1;
                    if (iter_cnt_q == LAST_IT) phase_q <= PH_FIX;
                end
                PH_FIX: begin
                    iter_cnt_q <= '0;
                    phase_q    <= PH_IDLE;
                end
                default: begin
                    iter_cnt_q <= '0;
                    phase_q    <= PH_IDLE;
                end
            endcase
        end
    end

    // One-cycle completion pulse after correction or a zero-divisor request.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= fix_o || zload_o;
    end

endmodule

// File: rtl/nrdiv_step.sv
// Module: nrdiv_step
// One non-restoring recurrence step. Shifts the partial remainder and the
// quotient/dividend word left together, then subtracts the divisor if the
// old partial remainder was non-negative, or adds it if it was negative.
// The new quotient bit enters on the right and is 1 when the result is
// non-negative. Assumes |rem_i| < div_i, so the result fits WIDTH+1 bits.
module nrdiv_step
    import nrdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   rem_i,
    input  logic [WIDTH-1:0] quo_i,
    input  logic [WIDTH-1:0] div_i,
    output logic [WIDTH:0]   rem_o,
    output logic [WIDTH-1:0] quo_o
);

    localparam int RW = WIDTH + 1;

    nrdiv_op_e      op;
    logic [RW-1:0]  shifted;
    logic [RW-1:0]  div_ext;

    // Choose direction from the old sign, form the doubled remainder, apply.
    always_comb begin
        op      = rem_i[WIDTH] ? OP_ADD : OP_SUB;
        shifted = {rem_i[WIDTH-1:0], quo_i[WIDTH-1]};
        div_ext = {1'b0, div_i};
        rem_o   = (op == OP_ADD) ? (shifted + div_ext) : (shifted - div_ext);
        quo_o   = {quo_i[WIDTH-2:0], ~rem_o[WIDTH]};
    end

endmodule

// File: rtl/nrdiv_fix.sv
// Module: nrdiv_fix
// Final correction: adds the divisor back once when the last partial
// remainder is negative, giving the true non-negative remainder.
// Assumes the partial remainder lies in [-div_i, div_i).
module nrdiv_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   rem_i,
    input  logic [WIDTH-1:0] div_i,
    output logic [WIDTH-1:0] rem_o
);

    logic [WIDTH:0] sum;

    // Conditional add-back selected by the remainder sign bit.
    always_comb begin
        sum   = rem_i + {1'b0, div_i};
        rem_o = rem_i[WIDTH] ? sum[WIDTH-1:0] : rem_i[WIDTH-1:0];
    end

endmodule

// File: rtl/nr_divider.sv
// Module: nr_divider
// Multi-cycle unsigned divider using the non-restoring method. Holds the
// working partial remainder (one bit wider than the divisor, for its sign),
// the shifting quotient/dividend word and the captured divisor, and keeps
// the last results on lo_o (quotient) and hi_o (remainder) until the next
// completion. Assumes start_i is only acted on while idle.
module nr_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             div_zero_o,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] hi_o
);

    logic             div_is_zero;
    logic             load, zload, iter, fix;
    logic [WIDTH:0]   rem_q, rem_nxt;
    logic [WIDTH-1:0] quo_q, quo_nxt;
    logic [WIDTH-1:0] div_q;
    logic [WIDTH-1:0] rem_fixed;
    logic [WIDTH-1:0] lo_q, hi_q;
    logic             dz_q;

    // Zero-divisor detect on the request operands.
    always_comb div_is_zero = (divisor_i == '0);

    nrdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .div_is_zero_i (div_is_zero),
        .load_o        (load),
        .zload_o       (zload),
        .iter_o        (iter),
        .fix_o         (fix),
        .busy_o        (busy_o),
        .done_o        (done_o)
    );

    nrdiv_step #(.WIDTH(WIDTH)) u_step (
        .rem_i (rem_q),
        .quo_i (quo_q),
        .div_i (div_q),
        .rem_o (rem_nxt),
        .quo_o (quo_nxt)
    );

    nrdiv_fix #(.WIDTH(WIDTH)) u_fix (
        .rem_i (rem_q),
        .div_i (div_q),
        .rem_o (rem_fixed)
    );

    // Working registers: load operands, then advance one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            div_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            div_q <= divisor_i;
        end else if (iter) begin
            rem_q <= rem_nxt;
            quo_q <= quo_nxt;
        end
    end

    // Result registers: written only at completion of a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            dz_q <= 1'b0;
        end else if (fix) begin
            lo_q <= quo_q;
            hi_q <= rem_fixed;
            dz_q <= 1'b0;
        end else if (zload) begin
            lo_q <= '1;
            hi_q <= dividend_i;
            dz_q <= 1'b1;
        end
    end

    // Drive the result ports.
    always_comb begin
        lo_o       = lo_q;
        hi_o       = hi_q;
        div_zero_o = dz_q;
    end

endmodule

// File: rtl/nrdiv_checker.sv
// Module: nrdiv_checker
// Port-level properties of nr_divider, attached with bind below.
// Assumes the same WIDTH as the bound instance.
module nrdiv_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [WIDTH-1:0] divisor_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             div_zero_o,
    input logic [WIDTH-1:0] lo_o,
    input logic [WIDTH-1:0] hi_o
);

    int unsigned      busy_len;
    logic [WIDTH-1:0] div_seen;

    // Counts the cycles of the current busy period.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_len <= 0;
        else if (busy_o) busy_len <= busy_len + 1;
        else             busy_len <= 0;
    end

    // Captures the divisor of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                  div_seen <= '0;
        else if (start_i && !busy_o) div_seen <= divisor_i;
    end

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len == WIDTH + 1) && done_o);

    assert_rem_below_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o) |-> (hi_o < div_seen));

    assert_zero_div_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && divisor_i == '0) |=> done_o && div_zero_o && !busy_o);

    assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(lo_o) && $stable(hi_o) && $stable(div_zero_o));

endmodule

bind nr_divider nrdiv_checker #(.WIDTH(WIDTH)) u_nrdiv_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .div_zero_o (div_zero_o),
    .lo_o       (lo_o),
    .hi_o       (hi_o)
);

// File: tb/tb_nr_divider.sv
// Bench for nr_divider: a behavioural per-cycle model predicts every output
// and is compared against the design on each falling edge.
module tb_nr_divider;

    localparam int W        = 32;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o, done_o, div_zero_o;
    logic [W-1:0] lo_o, hi_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    // Reference model state.
    bit           m_busy = 0, m_done = 0, m_dz = 0;
    logic [W-1:0] m_lo = '0, m_hi = '0, p_q = '0, p_r = '0;
    int           m_left = 0;

    nr_divider #(.WIDTH(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .div_zero_o (div_zero_o),
        .lo_o       (lo_o),
        .hi_o       (hi_o)
    );

    always #(CLK_PER/2) clk = ~clk;

    // Model update on each rising edge from the inputs driven at falling edges.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_lo = '0; m_hi = '0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_dz = 0; m_lo = p_q; m_hi = p_r;
                end
            end else if (start_i) begin
                if (divisor_i == 0) begin
                    m_done = 1; m_dz = 1; m_lo = '1; m_hi = dividend_i;
                end else begin
                    p_q = dividend_i / divisor_i;
                    p_r = dividend_i % divisor_i;
                    m_busy = 1; m_left = W + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy_o == m_busy, "R2 busy", W'(busy_o), W'(m_busy));
            chk(done_o == m_done, "R2 done", W'(done_o), W'(m_done));
            chk(div_zero_o == m_dz, "R5/R6 div_zero", W'(div_zero_o), W'(m_dz));
            chk(lo_o == m_lo, "R3/R8 quotient", lo_o, m_lo);
            chk(hi_o == m_hi, "R4/R8 remainder", hi_o, m_hi);
        end
    end

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        start_i = 1'b1; dividend_i = a; divisor_i = b;
        @(negedge clk);
        start_i = 1'b0; dividend_i = ~a; divisor_i = ~b;
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_PER * WATCHDOG);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] a, b;
        int unsigned sh;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values.
        chk(busy_o == 0 && done_o == 0 && div_zero_o == 0, "R1 flags",
            W'({busy_o, done_o, div_zero_o}), '0);
        chk(lo_o == 0 && hi_o == 0, "R1 results", lo_o | hi_o, '0);

        issue(32'd7, 32'd2);                 // R3/R4 small worked case
        issue(32'd11, 32'd3);
        issue(32'd26, 32'd5);
        issue(32'hFFFF_FFFF, 32'd1);         // R9 divisor one, all-ones dividend
        issue(32'd5, 32'd9);                 // R9 dividend below divisor
        issue(32'd0, 32'd17);                // R9 zero dividend
        issue(32'd1234, 32'd1234);
        issue(32'hFFFF_FFFF, 32'h8000_0001); // R9 divisor top bit set
        issue(32'h7FFF_FFFF, 32'hFFFF_FFFF);
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFE);
        issue(32'hFFFF_FFFF, 32'd7);
        issue(32'd99, 32'd0);                // R5 zero divisor
        issue(32'd0, 32'd0);
        issue(32'd100, 32'd7);               // R6 flag clears

        // R7: a start mid-operation must be ignored.
        @(negedge clk);
        start_i = 1'b1; dividend_i = 32'd1000; divisor_i = 32'd3;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        start_i = 1'b1; dividend_i = 32'd55; divisor_i = 32'd0;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
        chk(lo_o == 32'd333 && hi_o == 32'd1 && !div_zero_o, "R7 ignored start",
            lo_o, 32'd333);

        // R3/R4/R9: random operands with spread divisor widths.
        for (int i = 0; i < 60; i++) begin
            a  = $urandom;
            sh = $urandom_range(0, W - 1);
            b  = $urandom >> sh;
            if (b == 0) b = 32'd1;
            issue(a, b);
        end
        issue(32'd42, 32'd0);
        issue(32'hDEAD_BEEF, 32'h0001_0000);

        finish_run();
    end

endmodule